// File: doc/BRIEF.md
# Serial Flash Sync-Word Search Sequencer

This block is an SPI master that starts when `start` rises, typically at power-up. It looks for a configuration stream in an external serial flash. Each attempt pulls chip select low and sends a read opcode, a 24-bit zero start address and, for the fast-read opcode only, a run of dummy bytes. It then clocks a bounded search window. While the window runs, every MISO bit is shifted into a 32-bit register, which is compared against the sync pattern. Because the comparison is made on every bit, the pattern is found at any bit alignment.

If the window runs out, chip select is raised for a guard gap and the block tries again with the other opcode. A pass is one attempt with each opcode, and the sequencer makes a fixed number of passes. Once the pattern is found, chip select stays low and each following group of 8 received bits is presented as a byte with a one-cycle strobe. If every pass fails, the block raises a failure flag and releases all three SPI outputs, so that an external programmer can take over the flash.

All SPI timing is derived from the system clock through a fixed half-period divider. SPI mode 0 is used throughout.

Top module: `spiSyncSeeker`

## Requirements
- R1: After reset, and before any start, chip select is high, SCLK is low, all three output enables are high, and `syncFound`, `searchFail` and `byteValid` are low.
- R2: SPI mode 0 is used. SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled at the system clock edge on which SCLK rises.
- R3: The first attempt of each pass sends opcode 0x03 and then 24 zero address bits, MSB first, 32 SCLK rises in all. It then opens a search window of exactly `WINDOW` (default 512) further rises.
- R4: The second attempt of each pass sends opcode 0xE8, 24 zero address bits and `DUMMY_BYTES` (default 4) zero bytes, 64 rises by default. It then opens the same `WINDOW`-rise search window.
- R5: The sync word (default 0x5A3CC3A5) is accepted at any bit offset, including when its last bit is the final bit of the window. A copy whose last bit would fall one rise past the window is not accepted.
- R6: An all-ones MISO stream never matches. With such a stream the sequencer makes `PASSES` (default 4) passes, which is 8 attempts whose opcodes alternate 0x03, 0xE8, and each attempt uses its full command and window length.
- R7: Between attempts, chip select stays high for at least `GAP_PERIODS` (default 2) SCLK periods, and SCLK is low whenever chip select is high.
- R8: After the final attempt fails, `searchFail` is high and all three output enables are low. This state holds, even if `start` falls, until `start` rises again.
- R9: On a match, `syncFound` goes high and chip select stays low. Each later 8 received bits, MSB first, appear on `byteData` with `byteValid` high for exactly one cycle.
- R10: If `start` goes low while an attempt, a gap or the byte stream is active, chip select goes high, SCLK goes low and `syncFound` clears.
- R11: A rising edge of `start` in the failed state restarts from pass zero with opcode 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Rising edge begins a search; low aborts an active search |
| miso | input | 1 | Serial data from the flash |
| sclkOut | output | 1 | SPI clock |
| sclkOe | output | 1 | Output enable for SCLK |
| csNOut | output | 1 | Active-low chip select |
| csNOe | output | 1 | Output enable for chip select |
| mosiOut | output | 1 | Serial command data to the flash |
| mosiOe | output | 1 | Output enable for MOSI |
| syncFound | output | 1 | Sync pattern found; byte stream active |
| searchFail | output | 1 | All passes exhausted; bus released |
| byteData | output | 8 | Byte received after the sync pattern |
| byteValid | output | 1 | One-cycle strobe for `byteData` |

## Verification
The sequencer's state shows directly on the SPI pins. The number of SCLK rises inside each chip-select frame reveals a window or command counter that is off by one, as soon as that frame ends. The opcode captured at the start of each frame reveals a wrong opcode selection or pass count within 8 SCLK periods. A wrong alignment in the receive shift register shows up either as a missed match at a window edge or as wrong stream bytes within 8 SCLK periods of `syncFound`. A pass counter that is not cleared shows up as a restart that begins with the wrong opcode or gives up early.

// File: rtl/spiSyncPkg.sv
package spiSyncPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_SEARCH,
    ST_GAP,
    ST_STREAM,
    ST_FAIL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clkRun;    // SCLK may toggle
    logic forceLow;  // hold SCLK low
    logic divHold;   // keep divider at zero
    logic txLoad;    // load command register, clear receive register
    logic opSel;     // 0: first opcode, 1: second opcode
    logic txShift;   // advance MOSI on falling SCLK
    logic rxShift;   // shift MISO into sync register
    logic byteShift; // shift MISO into byte accumulator
    logic byteEmit;  // publish completed byte
  } seqStrobe_t;

endpackage

// File: rtl/spiSyncDatapath.sv
module spiSyncDatapath
  import spiSyncPkg::*;
#(
  parameter int          HALF_DIV   = 2,
  parameter logic [31:0] SYNC_WORD  = 32'h5A3C_C3A5,
  parameter logic [7:0]  OPC_FIRST  = 8'h03,
  parameter logic [7:0]  OPC_SECOND = 8'hE8,
  parameter int          TX_BITS    = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       miso,
  input  seqStrobe_t strb,
  output logic       wrap,
  output logic       riseEv,
  output logic       fallEv,
  output logic       sclk,
  output logic       mosi,
  output logic       matchNext,
  output logic [7:0] byteData,
  output logic       byteValid
);

  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0]      divCnt;
  logic [TX_BITS-1:0] txReg;
  logic [31:0]        rxReg;
  logic [31:0]        rxNext;
  logic [7:0]         byteAcc;

  assign wrap   = (divCnt == DW'(HALF_DIV - 1));
  assign riseEv = wrap && !sclk && strb.clkRun;
  assign fallEv = wrap && sclk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   divCnt <= '0;
    else if (strb.divHold || wrap) divCnt <= '0;
    else                         divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sclk <= 1'b0;
    else if (strb.forceLow)    sclk <= 1'b0;
    else if (riseEv || fallEv) sclk <= ~sclk;
  end

  // command shifter: opcode then zeros (address and dummy bytes)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      txReg <= '0;
    else if (strb.txLoad)
      txReg <= {(strb.opSel ? OPC_SECOND : OPC_FIRST), {(TX_BITS-8){1'b0}}};
    else if (strb.txShift)
      txReg <= {txReg[TX_BITS-2:0], 1'b0};
  end
  assign mosi = txReg[TX_BITS-1];

  // sync hunt register
  assign rxNext    = {rxReg[30:0], miso};
  assign matchNext = (rxNext == SYNC_WORD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxReg <= '0;
    else if (strb.txLoad)   rxReg <= '0;
    else if (strb.rxShift)  rxReg <= rxNext;
  end

  // post-sync byte assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteAcc   <= '0;
      byteData  <= '0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      if (strb.byteShift) byteAcc <= {byteAcc[6:0], miso};
      if (strb.byteEmit) begin
        byteData  <= {byteAcc[6:0], miso};
        byteValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spiSyncControl.sv
module spiSyncControl
  import spiSyncPkg::*;
#(
  parameter int WINDOW      = 512,
  parameter int PASSES      = 4,
  parameter int DUMMY_BYTES = 4,
  parameter int GAP_PERIODS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       wrap,
  input  logic       riseEv,
  input  logic       fallEv,
  input  logic       matchNext,
  output seqStrobe_t strb,
  output logic       csActive,
  output logic       syncFound,
  output logic       searchFail
);

  localparam int CMD_SHORT = 32;
  localparam int CMD_LONG  = 32 + 8 * DUMMY_BYTES;
  localparam int BW        = $clog2(CMD_LONG + 1);
  localparam int WW        = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam int PW        = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam int GAP_WRAPS = 2 * GAP_PERIODS;
  localparam int GW        = $clog2(GAP_WRAPS) + 1;

  seqState_t     state, stateNxt;
  logic          opSel, opSelNxt;
  logic [PW-1:0] passCnt, passCntNxt;
  logic [BW-1:0] bitCnt, bitCntNxt;
  logic [WW-1:0] winCnt, winCntNxt;
  logic [GW-1:0] gapCnt, gapCntNxt;
  logic          endPending, endPendingNxt;
  logic          startQ;
  logic          startRise;
  logic [BW-1:0] cmdBits;
  logic          active;

  assign startRise = start && !startQ;
  assign cmdBits   = opSel ? BW'(CMD_LONG) : BW'(CMD_SHORT);
  assign active    = (state == ST_CMD) || (state == ST_SEARCH) ||
                     (state == ST_GAP) || (state == ST_STREAM);

  always_comb begin
    stateNxt      = state;
    opSelNxt      = opSel;
    passCntNxt    = passCnt;
    bitCntNxt     = bitCnt;
    winCntNxt     = winCnt;
    gapCntNxt     = gapCnt;
    endPendingNxt = endPending;

    if (active && !start) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE, ST_FAIL: begin
          if (startRise) begin
            stateNxt   = ST_CMD;
            opSelNxt   = 1'b0;
            passCntNxt = '0;
            bitCntNxt  = '0;
            winCntNxt  = '0;
          end
        end
        ST_CMD: begin
          if (riseEv) bitCntNxt = bitCnt + 1'b1;
          else if (fallEv && bitCnt == cmdBits) begin
            stateNxt      = ST_SEARCH;
            winCntNxt     = '0;
            endPendingNxt = 1'b0;
          end
        end
        ST_SEARCH: begin
          if (riseEv) begin
            if (matchNext) begin
              stateNxt  = ST_STREAM;
              bitCntNxt = '0;
            end else if (winCnt == WW'(WINDOW - 1)) begin
              endPendingNxt = 1'b1;
            end else begin
              winCntNxt = winCnt + 1'b1;
            end
          end else if (fallEv && endPending) begin
            stateNxt  = ST_GAP;
            gapCntNxt = '0;
          end
        end
        ST_GAP: begin
          if (wrap) begin
            if (gapCnt == GW'(GAP_WRAPS - 1)) begin
              if (!opSel) begin
                stateNxt  = ST_CMD;
                opSelNxt  = 1'b1;
                bitCntNxt = '0;
              end else if (passCnt == PW'(PASSES - 1)) begin
                stateNxt = ST_FAIL;
              end else begin
                stateNxt   = ST_CMD;
                opSelNxt   = 1'b0;
                passCntNxt = passCnt + 1'b1;
                bitCntNxt  = '0;
              end
            end else begin
              gapCntNxt = gapCnt + 1'b1;
            end
          end
        end
        ST_STREAM: begin
          if (riseEv) bitCntNxt = (bitCnt == BW'(7)) ? '0 : bitCnt + 1'b1;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      opSel      <= 1'b0;
      passCnt    <= '0;
      bitCnt     <= '0;
      winCnt     <= '0;
      gapCnt     <= '0;
      endPending <= 1'b0;
      startQ     <= 1'b0;
    end else begin
      state      <= stateNxt;
      opSel      <= opSelNxt;
      passCnt    <= passCntNxt;
      bitCnt     <= bitCntNxt;
      winCnt     <= winCntNxt;
      gapCnt     <= gapCntNxt;
      endPending <= endPendingNxt;
      startQ     <= start;
    end
  end

  always_comb begin
    strb.clkRun    = (state == ST_CMD) || (state == ST_SEARCH) || (state == ST_STREAM);
    strb.forceLow  = (stateNxt == ST_IDLE) || (stateNxt == ST_FAIL) ||
                     (state == ST_IDLE) || (state == ST_FAIL) || (state == ST_GAP);
    strb.divHold   = (state == ST_IDLE) || (state == ST_FAIL);
    strb.txLoad    = (stateNxt == ST_CMD) && (state != ST_CMD);
    strb.opSel     = opSelNxt;
    strb.txShift   = (state == ST_CMD) && fallEv;
    strb.rxShift   = (state == ST_SEARCH) && riseEv;
    strb.byteShift = (state == ST_STREAM) && riseEv;
    strb.byteEmit  = (state == ST_STREAM) && riseEv && (bitCnt == BW'(7));
  end

  assign csActive   = (state == ST_CMD) || (state == ST_SEARCH) || (state == ST_STREAM);
  assign syncFound  = (state == ST_STREAM);
  assign searchFail = (state == ST_FAIL);

endmodule

// File: rtl/spiSyncSeeker.sv
module spiSyncSeeker
  import spiSyncPkg::*;
#(
  parameter int          HALF_DIV    = 2,
  parameter int          WINDOW      = 512,
  parameter int          PASSES      = 4,
  parameter int          DUMMY_BYTES = 4,
  parameter int          GAP_PERIODS = 2,
  parameter logic [31:0] SYNC_WORD   = 32'h5A3C_C3A5,
  parameter logic [7:0]  OPC_FIRST   = 8'h03,
  parameter logic [7:0]  OPC_SECOND  = 8'hE8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       miso,
  output logic       sclkOut,
  output logic       sclkOe,
  output logic       csNOut,
  output logic       csNOe,
  output logic       mosiOut,
  output logic       mosiOe,
  output logic       syncFound,
  output logic       searchFail,
  output logic [7:0] byteData,
  output logic       byteValid
);

  localparam int TX_BITS = 32 + 8 * DUMMY_BYTES;

  seqStrobe_t strb;
  logic       wrap, riseEv, fallEv, matchNext, csActive;

  spiSyncControl #(
    .WINDOW(WINDOW), .PASSES(PASSES),
    .DUMMY_BYTES(DUMMY_BYTES), .GAP_PERIODS(GAP_PERIODS)
  ) ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .wrap(wrap), .riseEv(riseEv), .fallEv(fallEv), .matchNext(matchNext),
    .strb(strb), .csActive(csActive),
    .syncFound(syncFound), .searchFail(searchFail)
  );

  spiSyncDatapath #(
    .HALF_DIV(HALF_DIV), .SYNC_WORD(SYNC_WORD),
    .OPC_FIRST(OPC_FIRST), .OPC_SECOND(OPC_SECOND), .TX_BITS(TX_BITS)
  ) dpath (
    .clk(clk), .rstN(rstN), .miso(miso), .strb(strb),
    .wrap(wrap), .riseEv(riseEv), .fallEv(fallEv),
    .sclk(sclkOut), .mosi(mosiOut), .matchNext(matchNext),
    .byteData(byteData), .byteValid(byteValid)
  );

  assign csNOut = !csActive;
  assign sclkOe = !searchFail;
  assign csNOe  = !searchFail;
  assign mosiOe = !searchFail;

endmodule

// File: rtl/spiSyncSeekerChk.sv
module spiSyncSeekerChk (
  input logic       clk,
  input logic       rstN,
  input logic       sclkOut,
  input logic       sclkOe,
  input logic       csNOut,
  input logic       csNOe,
  input logic       mosiOut,
  input logic       mosiOe,
  input logic       syncFound,
  input logic       searchFail,
  input logic       byteValid
);

  // R7
  cs_high_sclk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    csNOut |-> !sclkOut);

  // R2
  mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOut && $past(sclkOut)) |-> $stable(mosiOut));

  // R8
  fail_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    searchFail |-> (!sclkOe && !csNOe && !mosiOe));

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(syncFound && searchFail));

  // R9
  found_holds_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncFound |-> !csNOut);

  // R9
  byte_after_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> syncFound);

  // R9
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

endmodule

bind spiSyncSeeker spiSyncSeekerChk chkInst (
  .clk(clk), .rstN(rstN), .sclkOut(sclkOut), .sclkOe(sclkOe),
  .csNOut(csNOut), .csNOe(csNOe), .mosiOut(mosiOut), .mosiOe(mosiOe),
  .syncFound(syncFound), .searchFail(searchFail), .byteValid(byteValid)
);

// File: tb/tb_spiSyncSeeker.sv
`timescale 1ns/1ps
module tb_spiSyncSeeker;

  localparam logic [31:0] SYNC   = 32'h5A3C_C3A5;
  localparam int          WIN    = 512;
  localparam int          SHORTC = 32;
  localparam int          LONGC  = 64;
  localparam int          WD     = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic misoDrv = 1'b1;
  logic sclkOut, sclkOe, csNOut, csNOe, mosiOut, mosiOe;
  logic syncFound, searchFail, byteValid;
  logic [7:0] byteData;

  always #2.5 clk = ~clk;

  spiSyncSeeker dut (
    .clk(clk), .rstN(rstN), .start(start), .miso(misoDrv),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .csNOut(csNOut), .csNOe(csNOe),
    .mosiOut(mosiOut), .mosiOe(mosiOe), .syncFound(syncFound),
    .searchFail(searchFail), .byteData(byteData), .byteValid(byteValid)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // flash model configuration
  int cfgAttA = -1, cfgOffA = 0, cfgAttB = -1, cfgOffB = 0;

  int riseIdx = 0;
  int curAtt = -1;
  int attCount = 0;
  logic [7:0] opSeen = 8'h00;
  logic [7:0] attOp [16];
  int attRises [16];
  int attGap [16];
  int cmdOnes [16];
  int gapRun = 0;

  logic [7:0] byteLog [16];
  int byteCnt = 0;
  int validDouble = 0;
  logic prevValid = 1'b0;
  int modeViol = 0;
  int csViol = 0;
  logic prevSclk = 1'b0;
  logic prevMosi = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] payload(input int b);
    logic [7:0] t;
    t = 8'(b * 29);
    return 8'h5A ^ t;
  endfunction

  function automatic logic bitFor(input int att, input int k);
    int ds, j, off, p;
    logic [7:0] pb;
    ds = (opSeen == 8'hE8) ? LONGC : SHORTC;
    if (k < ds) return 1'b1;
    j = k - ds;
    if (att == cfgAttA) off = cfgOffA;
    else if (att == cfgAttB) off = cfgOffB;
    else return 1'b1;
    if (j < off) return 1'b1;
    if (j < off + 32) return SYNC[31 - (j - off)];
    p = j - off - 32;
    pb = payload(p / 8);
    return pb[7 - (p % 8)];
  endfunction

  always @(negedge csNOut) begin
    curAtt = attCount;
    if (curAtt < 16) begin
      attGap[curAtt] = gapRun;
      cmdOnes[curAtt] = 0;
    end
    attCount++;
    riseIdx = 0;
    opSeen = 8'h00;
    gapRun = 0;
    misoDrv = bitFor(curAtt, 0);
  end

  always @(posedge sclkOut) begin
    if (!csNOut) begin
      if (riseIdx < 8) opSeen = {opSeen[6:0], mosiOut};
      else if (riseIdx < ((opSeen == 8'hE8) ? LONGC : SHORTC) && mosiOut && curAtt >= 0 && curAtt < 16)
        cmdOnes[curAtt]++;
      riseIdx++;
    end
  end

  always @(negedge sclkOut) begin
    if (!csNOut) misoDrv = bitFor(curAtt, riseIdx);
  end

  always @(posedge csNOut) begin
    if (curAtt >= 0 && curAtt < 16) begin
      attRises[curAtt] = riseIdx;
      attOp[curAtt] = opSeen;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (csNOut === 1'b1) gapRun++;
    if (byteValid) begin
      if (byteCnt < 16) byteLog[byteCnt] = byteData;
      byteCnt++;
      if (prevValid) validDouble++;
    end
    prevValid = byteValid;
    if (rstN) begin
      if (sclkOut && prevSclk && (mosiOut !== prevMosi)) modeViol++;
      if (csNOut && sclkOut) csViol++;
    end
    prevSclk = sclkOut;
    prevMosi = mosiOut;
    if (cycles == WD) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearLogs();
    attCount = 0;
    curAtt = -1;
    byteCnt = 0;
    validDouble = 0;
    for (int i = 0; i < 16; i++) begin
      attRises[i] = 0; attOp[i] = 8'h00; attGap[i] = 0; cmdOnes[i] = 0;
    end
  endtask

  task automatic runSearch();
    @(negedge clk);
    start = 1'b1;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (syncFound || searchFail) break;
    end
  endtask

  task automatic stopAndCheck(input string req);
    @(negedge clk);
    start = 1'b0;
    waitCycles(3);
    check(csNOut == 1'b1, req, csNOut, 1);
    check(syncFound == 1'b0 && sclkOut == 1'b0, req, {syncFound, sclkOut}, 0);
    waitCycles(10);
  endtask

  task automatic testReset();
    check(csNOut == 1'b1 && sclkOut == 1'b0, "R1", {csNOut, sclkOut}, 2);
    check(sclkOe && csNOe && mosiOe, "R1", {sclkOe, csNOe, mosiOe}, 7);
    check(!syncFound && !searchFail && !byteValid, "R1",
          {syncFound, searchFail, byteValid}, 0);
  endtask

  task automatic checkBytes(input string req);
    waitCycles(200);
    check(byteCnt >= 4, req, byteCnt, 4);
    for (int b = 0; b < 4; b++)
      check(byteLog[b] == payload(b), req, byteLog[b], payload(b));
    check(validDouble == 0, req, validDouble, 0);
    check(csNOut == 1'b0 && syncFound, req, csNOut, 0);
  endtask

  task automatic testFirstHit();
    clearLogs();
    cfgAttA = 0; cfgOffA = 0; cfgAttB = -1;
    runSearch();
    check(syncFound == 1'b1, "R9", syncFound, 1);
    check(attCount == 1, "R3", attCount, 1);
    check(opSeen == 8'h03, "R3", opSeen, 8'h03);
    check(cmdOnes[0] == 0, "R3", cmdOnes[0], 0);
    checkBytes("R9");
    stopAndCheck("R10");
  endtask

  task automatic testWindowEdge();
    clearLogs();
    cfgAttA = 0; cfgOffA = WIN - 32; cfgAttB = -1;
    runSearch();
    check(syncFound == 1'b1 && attCount == 1, "R5", attCount, 1);
    checkBytes("R5");
    stopAndCheck("R10");
  endtask

  task automatic testFallback();
    clearLogs();
    cfgAttA = 0; cfgOffA = WIN - 31; cfgAttB = 1; cfgOffB = 5;
    runSearch();
    check(syncFound == 1'b1, "R5", syncFound, 1);
    check(attCount == 2, "R5", attCount, 2);
    check(attRises[0] == SHORTC + WIN, "R3", attRises[0], SHORTC + WIN);
    check(attOp[0] == 8'h03, "R3", attOp[0], 8'h03);
    check(opSeen == 8'hE8, "R4", opSeen, 8'hE8);
    check(cmdOnes[1] == 0, "R4", cmdOnes[1], 0);
    check(attGap[1] >= 8, "R7", attGap[1], 8);
    checkBytes("R9");
    stopAndCheck("R10");
  endtask

  task automatic testBlank();
    clearLogs();
    cfgAttA = -1; cfgAttB = -1;
    runSearch();
    check(searchFail == 1'b1 && !syncFound, "R6", searchFail, 1);
    check(attCount == 8, "R6", attCount, 8);
    for (int a = 0; a < 8; a++) begin
      check(attOp[a] == ((a % 2 == 0) ? 8'h03 : 8'hE8), "R6", attOp[a],
            (a % 2 == 0) ? 8'h03 : 8'hE8);
      check(attRises[a] == ((a % 2 == 0) ? SHORTC + WIN : LONGC + WIN), "R6",
            attRises[a], (a % 2 == 0) ? SHORTC + WIN : LONGC + WIN);
      if (a > 0) check(attGap[a] >= 8, "R7", attGap[a], 8);
    end
    check(!sclkOe && !csNOe && !mosiOe, "R8", {sclkOe, csNOe, mosiOe}, 0);
    @(negedge clk);
    start = 1'b0;
    waitCycles(20);
    check(searchFail == 1'b1 && !csNOe, "R8", {searchFail, csNOe}, 2);
  endtask

  task automatic testRestart();
    clearLogs();
    cfgAttA = 0; cfgOffA = 13; cfgAttB = -1;
    runSearch();
    check(syncFound == 1'b1 && !searchFail, "R11", syncFound, 1);
    check(attCount == 1 && opSeen == 8'h03, "R11", opSeen, 8'h03);
    check(sclkOe && csNOe && mosiOe, "R11", {sclkOe, csNOe, mosiOe}, 7);
    checkBytes("R9");
    stopAndCheck("R10");
  endtask

  task automatic testAbortSearch();
    clearLogs();
    cfgAttA = -1; cfgAttB = -1;
    @(negedge clk);
    start = 1'b1;
    waitCycles(700);
    check(csNOut == 1'b0, "R10", csNOut, 0);
    stopAndCheck("R10");
  endtask

  initial begin
    waitCycles(4);
    rstN = 1'b1;
    waitCycles(4);
    testReset();
    testFirstHit();
    testWindowEdge();
    testFallback();
    testBlank();
    testRestart();
    testAbortSearch();
    check(modeViol == 0, "R2", modeViol, 0);
    check(csViol == 0, "R7", csViol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule